// File: doc/BRIEF.md
# Free-Block Watermark Monitor

This block watches the free-block count that a packet-buffer manager reports. Each cycle it compares that count with three programmable lower limits. Each limit drives its own action. The first raises a sticky interrupt for the host. The second holds the MAC receiver in a halted state. The third fires a single-cycle request to send a flow-control PAUSE frame. A limit programmed to zero switches its action off. The buffer manager, the PAUSE frame builder and the receive datapath are outside this block.

The host writes the limits through a small write port. A selector code picks the target of each write. The same port also carries a write-one-to-clear acknowledge for the interrupt. A read output returns the free count, registered once. Every output is registered, so a change on an input shows at the outputs one clock later.

Top module: `free_wm_mon`

## Requirements
- R1: After reset, `irq`, `rx_halt`, `pause_req` and `rd_free` are 0. The interrupt limit resets to 0, the halt limit to 4 and the PAUSE limit to 0.
- R2: `rd_free` equals the value `free_cnt` had on the previous clock edge.
- R3: A write with `wr_en`=1 loads `wr_data` into a limit chosen by `wr_sel`: 0 selects the interrupt limit, 1 the halt limit and 2 the PAUSE limit. The new value is first used in the comparison at the clock edge after the write edge.
- R4: `rx_halt` is 1 in the cycle after an edge where `free_cnt` was below a nonzero halt limit, and 0 otherwise.
- R5: `pause_req` is high for exactly one cycle when the count enters the below-limit state for a nonzero PAUSE limit. It does not fire again until the count has been at or above the limit for at least one edge.
- R6: `irq` sets when the count enters the below-limit state for a nonzero interrupt limit. It then stays set after the count recovers.
- R7: A write with `wr_sel`=3 and `wr_data[0]`=1 clears `irq`. The same write with `wr_data[0]`=0 has no effect. A new interrupt event at the same edge wins over the clear.
- R8: A limit of zero disables its action: no interrupt, no halt and no PAUSE request, whatever the count is, including 0.
- R9: The comparison is strict. A count equal to a limit does not count as below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| free_cnt | input | CNT_W | Free-block count from the buffer manager |
| wr_en | input | 1 | Write strobe for the register port |
| wr_sel | input | 2 | Write target: 0 interrupt limit, 1 halt limit, 2 PAUSE limit, 3 interrupt acknowledge |
| wr_data | input | CNT_W | Write data; bit 0 is the clear flag when `wr_sel`=3 |
| rd_free | output | CNT_W | Registered copy of the free count |
| irq | output | 1 | Sticky interrupt request |
| rx_halt | output | 1 | Receive-halt level |
| pause_req | output | 1 | One-cycle PAUSE transmit request |

## Verification
The bench builds the block with `CNT_W`=5 and keeps the default reset limits: 0 for the interrupt, 4 for the halt and 0 for the PAUSE. With 32 possible values, a random count stream reaches a count of 0, the largest count, and exact equality with every limit many times. Random writes often land on the same edge as an entry into the below-limit state, so a clear and a new interrupt event meet at one edge. The narrow width also makes it cheap to reprogram a limit to zero while its action is active, or to a value just above the current count.

// File: rtl/fwm_pkg.sv
package fwm_pkg;
  // write selector codes
  typedef enum logic [1:0] {
    SEL_IRQ   = 2'd0,
    SEL_HALT  = 2'd1,
    SEL_PAUSE = 2'd2,
    SEL_ACK   = 2'd3
  } fwm_sel_e;

  // channel indices inside the threshold vector
  localparam int CH_IRQ   = 0;
  localparam int CH_HALT  = 1;
  localparam int CH_PAUSE = 2;
  localparam int NUM_CH   = 3;
endpackage

// File: rtl/fwm_thr_regs.sv
module fwm_thr_regs
  import fwm_pkg::*;
#(
  parameter int W         = 7,
  parameter int IRQ_RST   = 0,
  parameter int HALT_RST  = 4,
  parameter int PAUSE_RST = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [1:0]                 wr_sel,
  input  logic [W-1:0]               wr_data,
  output logic [NUM_CH-1:0][W-1:0]   thr_q
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_thr
    localparam logic [W-1:0] RST_VAL =
      (g == CH_IRQ)  ? W'(IRQ_RST)  :
      (g == CH_HALT) ? W'(HALT_RST) : W'(PAUSE_RST);
    logic hit;
    assign hit = wr_en && (wr_sel == 2'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   thr_q[g] <= RST_VAL;
      else if (hit) thr_q[g] <= wr_data;
    end
  end
endmodule

// File: rtl/fwm_cmp.sv
module fwm_cmp #(
  parameter int W = 7
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] thr,
  output logic         below
);
  // strict less-than, zero limit means disabled
  function automatic logic under_limit(input logic [W-1:0] c, input logic [W-1:0] t);
    return (t != '0) && (c < t);
  endfunction

  assign below = under_limit(cnt, thr);
endmodule

// File: rtl/fwm_actions.sv
module fwm_actions (
  input  logic clk,
  input  logic rst_n,
  input  logic below_irq,
  input  logic below_halt,
  input  logic below_pause,
  input  logic ack,
  output logic irq_set,
  output logic pause_fire,
  output logic irq,
  output logic rx_halt,
  output logic pause_req
);
  logic prev_irq_q;
  logic armed_q;

  assign irq_set    = below_irq & ~prev_irq_q;
  assign pause_fire = below_pause & armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_irq_q <= 1'b0;
      irq        <= 1'b0;
    end else begin
      prev_irq_q <= below_irq;
      if (irq_set)  irq <= 1'b1;
      else if (ack) irq <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b1;
      pause_req <= 1'b0;
    end else begin
      pause_req <= pause_fire;
      if (pause_fire)       armed_q <= 1'b0;
      else if (!below_pause) armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_halt <= 1'b0;
    else        rx_halt <= below_halt;
  end
endmodule

// File: rtl/free_wm_mon.sv
module free_wm_mon
  import fwm_pkg::*;
#(
  parameter int CNT_W     = 7,
  parameter int IRQ_RST   = 0,
  parameter int HALT_RST  = 4,
  parameter int PAUSE_RST = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] free_cnt,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] rd_free,
  output logic             irq,
  output logic             rx_halt,
  output logic             pause_req
);
  logic [NUM_CH-1:0][CNT_W-1:0] thr_vec;
  logic [NUM_CH-1:0]            below_vec;
  logic                         ack_req;
  logic                         irq_set;
  logic                         pause_fire;

  assign ack_req = wr_en && (wr_sel == SEL_ACK) && wr_data[0];

  fwm_thr_regs #(
    .W(CNT_W), .IRQ_RST(IRQ_RST), .HALT_RST(HALT_RST), .PAUSE_RST(PAUSE_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .thr_q(thr_vec)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
    fwm_cmp #(.W(CNT_W)) u_cmp (
      .cnt(free_cnt), .thr(thr_vec[g]), .below(below_vec[g])
    );
  end

  fwm_actions u_act (
    .clk(clk), .rst_n(rst_n),
    .below_irq(below_vec[CH_IRQ]), .below_halt(below_vec[CH_HALT]),
    .below_pause(below_vec[CH_PAUSE]), .ack(ack_req),
    .irq_set(irq_set), .pause_fire(pause_fire),
    .irq(irq), .rx_halt(rx_halt), .pause_req(pause_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_free <= '0;
    else        rd_free <= free_cnt;
  end
endmodule

// File: rtl/fwm_chk.sv
module fwm_chk
  import fwm_pkg::*;
#(
  parameter int W = 7
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [W-1:0]             free_cnt,
  input logic [W-1:0]             rd_free,
  input logic [NUM_CH-1:0][W-1:0] thr_vec,
  input logic [NUM_CH-1:0]        below_vec,
  input logic                     ack_req,
  input logic                     irq,
  input logic                     rx_halt,
  input logic                     pause_req
);
  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  // R2
  rd_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> rd_free == $past(free_cnt));

  // R4
  halt_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> rx_halt == $past(below_vec[CH_HALT]));

  // R5
  pause_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req |=> !pause_req);

  // R5
  pause_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && pause_req) |-> $past(below_vec[CH_PAUSE]));

  // R6
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $rose(irq)) |-> $past(below_vec[CH_IRQ]));

  // R7
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $fell(irq)) |-> $past(ack_req));

  // R8
  zero_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(thr_vec[CH_HALT]) == '0) |-> !rx_halt);
endmodule

bind free_wm_mon fwm_chk #(.W(CNT_W)) u_fwm_chk (
  .clk(clk), .rst_n(rst_n), .free_cnt(free_cnt), .rd_free(rd_free),
  .thr_vec(thr_vec), .below_vec(below_vec), .ack_req(ack_req),
  .irq(irq), .rx_halt(rx_halt), .pause_req(pause_req)
);

// File: tb/test_free_wm_mon.sv
module test_free_wm_mon;
  localparam int W = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] free_cnt = '0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_free;
  logic         irq, rx_halt, pause_req;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #10 clk = ~clk;  // 50 MHz

  free_wm_mon #(.CNT_W(W)) i_free_wm_mon (
    .clk(clk), .rst_n(rst_n), .free_cnt(free_cnt), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_free(rd_free),
    .irq(irq), .rx_halt(rx_halt), .pause_req(pause_req)
  );

  // behavioural reference
  int m_thr[3];
  int m_rd;
  bit m_irq, m_halt, m_pause, m_armed, m_prev;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_thr[0] = 0; m_thr[1] = 4; m_thr[2] = 0;
      m_rd = 0; m_irq = 0; m_halt = 0; m_pause = 0; m_armed = 1; m_prev = 0;
    end else begin
      int f;
      bit bi, bh, bp, ack;
      f  = int'(free_cnt);
      bi = (m_thr[0] > 0) && (f < m_thr[0]);
      bh = (m_thr[1] > 0) && (f < m_thr[1]);
      bp = (m_thr[2] > 0) && (f < m_thr[2]);
      ack = wr_en && (wr_sel == 2'd3) && wr_data[0];
      m_rd = f;
      m_halt = bh;
      if (bp && m_armed) begin m_pause = 1; m_armed = 0; end
      else begin m_pause = 0; if (!bp) m_armed = 1; end
      if (bi && !m_prev) m_irq = 1;
      else if (ack)      m_irq = 0;
      m_prev = bi;
      if (wr_en && wr_sel != 2'd3) m_thr[wr_sel] = int'(wr_data);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("[TB] FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 rd_free model", int'(rd_free), m_rd);
      check("R4 rx_halt model", int'(rx_halt), int'(m_halt));
      check("R5 pause_req model", int'(pause_req), int'(m_pause));
      check("R6 irq model", int'(irq), int'(m_irq));
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int sel, input int data);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = W'(data);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_checks++; n_fail++;
      $display("[TB] FAIL watchdog expired actual=%0d expected=done", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values before any edge out of reset
    check("R1 irq", int'(irq), 0);
    check("R1 rx_halt", int'(rx_halt), 0);
    check("R1 pause_req", int'(pause_req), 0);
    check("R1 rd_free", int'(rd_free), 0);
    rst_n = 1'b1;

    // R1 default halt limit 4
    free_cnt = 5'd3; tick();
    check("R1 halt default", int'(rx_halt), 1);
    check("R2 rd_free", int'(rd_free), 3);
    free_cnt = 5'd4; tick();
    check("R9 equal not below", int'(rx_halt), 0);

    // R3 write timing
    free_cnt = 5'd6;
    wr(1, 8);
    check("R3 old limit at write edge", int'(rx_halt), 0);
    tick();
    check("R3 new limit applied", int'(rx_halt), 1);

    // R8 halt disabled
    wr(1, 0);
    tick();
    check("R8 halt off", int'(rx_halt), 0);
    free_cnt = 5'd0; tick();
    check("R8 halt off at zero", int'(rx_halt), 0);
    check("R8 irq off at zero", int'(irq), 0);
    check("R8 pause off at zero", int'(pause_req), 0);

    // R5 pause strobe
    free_cnt = 5'd20;
    wr(2, 10);
    free_cnt = 5'd9; tick();
    check("R5 pause fires", int'(pause_req), 1);
    tick();
    check("R5 pause one cycle", int'(pause_req), 0);
    free_cnt = 5'd5; tick();
    check("R5 no refire below", int'(pause_req), 0);
    free_cnt = 5'd10; tick();
    check("R9 pause equal", int'(pause_req), 0);
    free_cnt = 5'd9; tick();
    check("R5 refire after recovery", int'(pause_req), 1);

    // R6 sticky interrupt
    free_cnt = 5'd12;
    wr(0, 6);
    free_cnt = 5'd5; tick();
    check("R6 irq sets", int'(irq), 1);
    free_cnt = 5'd20; tick();
    check("R6 irq sticky", int'(irq), 1);

    // R7 clear behaviour
    wr(3, 0);
    check("R7 ack bit0 zero ignored", int'(irq), 1);
    wr(3, 1);
    check("R7 ack clears", int'(irq), 0);
    free_cnt = 5'd5;
    wr(3, 1);
    check("R7 set wins over clear", int'(irq), 1);

    // random phase, compared against the model every cycle
    for (int i = 0; i < 3000; i++) begin
      free_cnt = W'($urandom_range(0, 31));
      if ($urandom_range(0, 7) == 0) begin
        wr_en = 1'b1;
        wr_sel = 2'($urandom_range(0, 3));
        wr_data = W'($urandom_range(0, 31));
      end else begin
        wr_en = 1'b0;
      end
      tick();
    end
    wr_en = 1'b0;
    finish_run();
  end
endmodule